// File: doc/BRIEF.md
# One-Time-Programmable Protection Register

This block holds a small security record of 16-bit words: a read-only factory segment that carries a unique identifier, a user segment that software can program once, and a lock word. The identifier is fixed at build time through a parameter. The user segment and the lock bits are stored in registers that come out of reset at all ones. A program request can only clear bits. Each request carries a word address and 16 bits of data. A legal request occupies the block for a fixed, parameterised number of cycles. During that time `busy` is high and every read returns a status word in place of data.

The lock bits form a hierarchy. Clearing the user-lock bit freezes the user segment, and it also freezes the security-lock bit unless that bit has already been cleared. Clearing the security-lock bit raises `sec_blk_lock`, which neighbouring block-protection logic uses to keep the security parameter block permanently protected. A request that is illegal is dropped at once, leaves every stored bit as it was, and raises `prog_err`. A request is illegal if it targets a protected or unmapped word, or if its data holds a 1 where the stored bit is already 0.

Top module: `otp_protect_reg`

## Requirements
- R1: After reset, `busy`, `prog_err` and `sec_blk_lock` are 0, every user word reads 16'hFFFF and the lock word reads 16'hFFFE.
- R2: Word addresses 0..FACT_WORDS-1 read the factory segment, where word i is FACTORY_ID[16*i +: 16]. The next USER_WORDS addresses read the user segment. The address right after the user segment reads the lock word. Every higher address reads 16'hFFFF.
- R3: An accepted request raises `busy` at the next edge and holds it for exactly PROG_CYCLES cycles. When `busy` falls, the target word reads its old value ANDed with the request data.
- R4: While `busy` is high, `rd_data` is 16'h0000 for every address.
- R5: A request whose data has a 1 in any position where the target currently reads 0 sets `prog_err` at the next edge, does not raise `busy`, and changes no stored bit.
- R6: A request to a factory word or to an unmapped address sets `prog_err`, does not raise `busy`, and changes nothing.
- R7: Once lock bit 1 reads 0, any request to a user word is rejected with `prog_err`.
- R8: Once lock bit 1 reads 0, a request that would clear lock bit 2 while that bit is still 1 is rejected with `prog_err`.
- R9: `sec_blk_lock` rises when lock bit 2 has been cleared and never falls again before reset.
- R10: A request presented while `busy` is high is ignored. It changes no data and leaves `prog_err` unchanged.
- R11: Each request that is not ignored overwrites `prog_err`: 1 if the request is rejected, 0 if it is accepted.
- R12: The lock word reads as ones in bits 15..3, lock bit 2 in bit 2, lock bit 1 in bit 1, and a constant 0 in bit 0. Only bits 2 and 1 can be programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_req | input | 1 | Program request, sampled each edge |
| prog_addr | input | ADDR_W | Word address of the request |
| prog_data | input | WORD_W | Data of the request; 0 bits clear |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | WORD_W | Read word, or status while busy |
| busy | output | 1 | Programming in progress |
| prog_err | output | 1 | Last request that was not ignored was rejected |
| sec_blk_lock | output | 1 | Security parameter block is permanently protected |

## Verification
The bench builds the block with four factory words, four user words, a known 64-bit identifier and a programming time of three cycles. With 4-bit addresses, every address, including the seven unmapped ones, can be swept after each operation and compared against a bench model. The short programming time lets the bench count every busy window and place a second request inside one. Each lock ordering is run from a fresh reset, so that both branches of the lock hierarchy are reached.

// File: rtl/otp_pkg.sv
// Shared definitions for the one-time-programmable protection register.
// Assumes 16-bit or wider words; lock-word bit positions are fixed here.
package otp_pkg;

    typedef enum logic [1:0] {
        RG_FACT = 2'd0,
        RG_USER = 2'd1,
        RG_LOCK = 2'd2,
        RG_NONE = 2'd3
    } otp_region_e;

    localparam int LOCK_FACT_BIT = 0;
    localparam int LOCK_USER_BIT = 1;
    localparam int LOCK_SEC_BIT  = 2;

endpackage

// File: rtl/otp_prog_seq.sv
// Program sequencer: captures an accepted request, holds busy for
// PROG_CYCLES cycles and pulses commit in the last one.
// Assumes start is only asserted while busy is low; PROG_CYCLES >= 1.
module otp_prog_seq #(
    parameter int PROG_CYCLES = 8,
    parameter int ADDR_W      = 4,
    parameter int WORD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] data_in,
    output logic              busy,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [WORD_W-1:0] c_data
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Busy window and countdown of remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CNT_W'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // Capture address and data of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_addr <= '0;
            c_data <= '1;
        end else if (start) begin
            c_addr <= addr_in;
            c_data <= data_in;
        end
    end

    // Commit happens in the last busy cycle.
    assign commit = busy && (remain == '0);
endmodule

// File: rtl/otp_store.sv
// Storage of the user segment and the lock bits, plus two read ports
// (one for the bus, one for request checking) and address classification.
// Assumes commit targets only a legal user word or the lock word.
module otp_store
    import otp_pkg::*;
#(
    parameter int          FACT_WORDS = 4,
    parameter int          USER_WORDS = 4,
    parameter int          WORD_W     = 16,
    parameter int          ADDR_W     = 4,
    parameter logic [FACT_WORDS*WORD_W-1:0] FACTORY_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [WORD_W-1:0] c_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    input  logic [ADDR_W-1:0] q_addr,
    output logic [WORD_W-1:0] q_word,
    output otp_region_e       q_region,
    output logic              user_open,
    output logic              sec_open
);
    localparam int LOCK_ADDR = FACT_WORDS + USER_WORDS;

    logic [WORD_W-1:0] user_mem [USER_WORDS];
    logic              lk_user;
    logic              lk_sec;

    function automatic otp_region_e classify(input logic [ADDR_W-1:0] a);
        int idx = int'(a);
        if (idx < FACT_WORDS)       return RG_FACT;
        else if (idx < LOCK_ADDR)   return RG_USER;
        else if (idx == LOCK_ADDR)  return RG_LOCK;
        else                        return RG_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] fetch(input logic [ADDR_W-1:0] a);
        int idx = int'(a);
        logic [WORD_W-1:0] w;
        w = '1;
        case (classify(a))
            RG_FACT: w = FACTORY_ID[idx*WORD_W +: WORD_W];
            RG_USER: w = user_mem[idx - FACT_WORDS];
            RG_LOCK: begin
                w = '1;
                w[LOCK_FACT_BIT] = 1'b0;
                w[LOCK_USER_BIT] = lk_user;
                w[LOCK_SEC_BIT]  = lk_sec;
            end
            default: w = '1;
        endcase
        return w;
    endfunction

    // One storage word per user slot; bits may only be cleared.
    for (genvar g = 0; g < USER_WORDS; g++) begin : g_user
        always_ff @(posedge clk) begin
            if (!rst_n)
                user_mem[g] <= '1;
            else if (commit && int'(c_addr) == FACT_WORDS + g)
                user_mem[g] <= user_mem[g] & c_data;
        end
    end

    // Lock bits; clear-only like the user words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_user <= 1'b1;
            lk_sec  <= 1'b1;
        end else if (commit && classify(c_addr) == RG_LOCK) begin
            lk_user <= lk_user & c_data[LOCK_USER_BIT];
            lk_sec  <= lk_sec  & c_data[LOCK_SEC_BIT];
        end
    end

    // Read ports.
    always_comb begin
        rd_word  = fetch(rd_addr);
        q_word   = fetch(q_addr);
        q_region = classify(q_addr);
    end

    assign user_open = lk_user;
    assign sec_open  = lk_sec;
endmodule

// File: rtl/otp_protect_reg.sv
// Top of the protection register: screens program requests against the
// lock hierarchy and the clear-only rule, then hands legal ones to the
// sequencer. Assumes WORD_W >= 4 so the lock bits fit.
module otp_protect_reg
    import otp_pkg::*;
#(
    parameter int FACT_WORDS  = 4,
    parameter int USER_WORDS  = 4,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 8,
    parameter logic [FACT_WORDS*WORD_W-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF,
    parameter int ADDR_W      = $clog2(FACT_WORDS + USER_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              prog_err,
    output logic              sec_blk_lock
);
    localparam logic [WORD_W-1:0] STATUS_BUSY = '0;

    logic              commit;
    logic [ADDR_W-1:0] c_addr;
    logic [WORD_W-1:0] c_data;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] q_word;
    otp_region_e       q_region;
    logic              user_open;
    logic              sec_open;
    logic              take;
    logic              reject;

    otp_store #(
        .FACT_WORDS(FACT_WORDS), .USER_WORDS(USER_WORDS), .WORD_W(WORD_W),
        .ADDR_W(ADDR_W), .FACTORY_ID(FACTORY_ID)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_addr(c_addr),
        .c_data(c_data), .rd_addr(rd_addr), .rd_word(rd_word),
        .q_addr(prog_addr), .q_word(q_word), .q_region(q_region),
        .user_open(user_open), .sec_open(sec_open)
    );

    // Request screening: region, lock hierarchy and clear-only rule.
    always_comb begin
        take   = prog_req && !busy;
        reject = 1'b0;
        if ((prog_data & ~q_word) != '0) reject = 1'b1;
        case (q_region)
            RG_FACT, RG_NONE: reject = 1'b1;
            RG_USER: if (!user_open) reject = 1'b1;
            RG_LOCK: if (!user_open && sec_open && !prog_data[LOCK_SEC_BIT])
                         reject = 1'b1;
            default: reject = 1'b1;
        endcase
    end

    otp_prog_seq #(
        .PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(take && !reject),
        .addr_in(prog_addr), .data_in(prog_data), .busy(busy),
        .commit(commit), .c_addr(c_addr), .c_data(c_data)
    );

    // Error flag follows the verdict of each request that is not ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)    prog_err <= 1'b0;
        else if (take) prog_err <= reject;
    end

    assign rd_data      = busy ? STATUS_BUSY : rd_word;
    assign sec_blk_lock = !sec_open;
endmodule

// File: rtl/otp_protect_chk.sv
// Checker for otp_protect_reg, observing its ports only.
// Assumes synchronous active-low reset held from time zero.
module otp_protect_chk #(
    parameter int FACT_WORDS  = 4,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 8,
    parameter int ADDR_W      = 4,
    parameter logic [FACT_WORDS*WORD_W-1:0] FACTORY_ID = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              prog_err,
    input logic              sec_blk_lock,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data
);
    int busy_len;

    // Length of the current busy run, counted in sampled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R3
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == PROG_CYCLES);

    // R11
    accept_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !prog_err);

    // R10
    ignore_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(prog_err));

    // R9
    sec_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_blk_lock |=> sec_blk_lock);

    // R2
    factory_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && int'(rd_addr) < FACT_WORDS) |->
            rd_data == FACTORY_ID[int'(rd_addr)*WORD_W +: WORD_W]);

    // R4
    status_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_data == '0);
endmodule

bind otp_protect_reg otp_protect_chk #(
    .FACT_WORDS(FACT_WORDS), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES),
    .ADDR_W(ADDR_W), .FACTORY_ID(FACTORY_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .prog_err(prog_err),
    .sec_blk_lock(sec_blk_lock), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_otp_protect_reg.sv
`timescale 1ns/1ps
module tb_otp_protect_reg;
    localparam int          P   = 3;
    localparam logic [63:0] FID = 64'h1234_5678_9ABC_DEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_req = 1'b0;
    logic [3:0]  prog_addr = '0;
    logic [15:0] prog_data = '1;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy, prog_err, sec_blk_lock;

    int n_vec = 0;
    int n_fail = 0;
    logic [15:0] model [16];

    otp_protect_reg #(
        .FACT_WORDS(4), .USER_WORDS(4), .WORD_W(16), .PROG_CYCLES(P),
        .FACTORY_ID(FID)
    ) dut (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .prog_err(prog_err), .sec_blk_lock(sec_blk_lock)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_init();
        for (int a = 0; a < 16; a++) model[a] = 16'hFFFF;
        for (int a = 0; a < 4; a++) model[a] = FID[a*16 +: 16];
        model[8] = 16'hFFFE;
    endtask

    function automatic bit exp_bad(input logic [3:0] a, input logic [15:0] d);
        bit lk1 = model[8][1];
        bit lk2 = model[8][2];
        if (a < 4 || a > 8) return 1'b1;
        if ((d & ~model[a]) != 16'h0) return 1'b1;
        if (a >= 4 && a <= 7 && !lk1) return 1'b1;
        if (a == 8 && !lk1 && lk2 && !d[2]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; prog_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_init();
        #1;
        chk(busy, 0, "R1 busy after reset");
        chk(prog_err, 0, "R1 err after reset");
        chk(sec_blk_lock, 0, "R1 sec lock after reset");
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #1;
            chk(rd_data, model[a], tag);
        end
    endtask

    task automatic prog(input logic [3:0] a, input logic [15:0] d, input string tag);
        bit eb = exp_bad(a, d);
        int n = 0;
        @(negedge clk);
        prog_req = 1'b1; prog_addr = a; prog_data = d;
        @(negedge clk);
        prog_req = 1'b0;
        chk(prog_err, 32'(eb), {tag, " R11 err verdict"});
        if (!eb) begin
            rd_addr = 4'd0;
            #1;
            chk(rd_data, 16'h0000, "R4 status while busy");
            while (busy && n < 50) begin
                n++;
                @(negedge clk);
            end
            chk(n, P, "R3 busy length");
            if (a == 8) model[8][2:1] = model[8][2:1] & d[2:1];
            else        model[a] = model[a] & d;
        end else begin
            chk(busy, 0, {tag, " no busy on reject"});
        end
        sweep({tag, " contents"});
    endtask

    initial begin
        #(4.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        model_init();
        do_reset();
        sweep("R1 R2 R12 reset contents");

        // R3 and R5 per user word: two clearing writes, then a set attempt.
        for (int u = 0; u < 4; u++) begin
            prog(4'(4 + u), 16'hFFFF ^ (16'h0007 << (u * 3)), "R3 clear A");
            prog(4'(4 + u), model[4 + u] & 16'hF0FF, "R3 clear B");
            prog(4'(4 + u), 16'hFFFF, "R5 set attempt");
            prog(4'(4 + u), model[4 + u] | 16'h0100, "R5 single set bit");
            prog(4'(4 + u), model[4 + u], "R11 no-change accept");
        end

        // R6 factory and unmapped addresses.
        for (int a = 0; a < 16; a++) begin
            if (a < 4 || a > 8) prog(4'(a), 16'h0000, "R6 protected address");
        end

        // R12 lock word bit 0 cannot be set back.
        prog(4'd8, 16'hFFFF, "R12 lock bit0 set attempt");

        // R10 request while busy is ignored.
        @(negedge clk);
        prog_req = 1'b1; prog_addr = 4'd4; prog_data = model[4] & 16'hFF0F;
        for (int j = 1; j <= P; j++) begin
            @(negedge clk);
            if (j == 1) begin prog_addr = 4'd5; prog_data = 16'h0000; end
            if (j == P) prog_req = 1'b0;
        end
        @(negedge clk);
        model[4] = model[4] & 16'hFF0F;
        chk(busy, 0, "R10 busy done");
        chk(prog_err, 0, "R10 err unchanged");
        sweep("R10 ignored write");

        // R7 and R8: lock user segment first.
        prog(4'd8, 16'hFFFC, "R12 clear user lock");
        chk(sec_blk_lock, 0, "R9 no sec lock yet");
        prog(4'd5, 16'h0000, "R7 user write after lock");
        prog(4'd8, 16'hFFF8, "R8 sec lock after user lock");
        chk(sec_blk_lock, 0, "R8 sec lock stays clear");

        // R9: fresh reset, security lock first, then user lock still allowed.
        do_reset();
        sweep("R1 contents after second reset");
        prog(4'd8, 16'hFFFA, "R9 clear sec lock");
        chk(sec_blk_lock, 1, "R9 sec lock raised");
        prog(4'd8, 16'hFFF8, "R12 clear user lock after sec");
        repeat (5) @(negedge clk);
        chk(sec_blk_lock, 1, "R9 sec lock held");
        prog(4'd8, 16'hFFFE, "R5 lock set attempt");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule